// File: doc/BRIEF.md
# Receiver Polling Wake-Up Controller

This block runs the duty cycle of a low-power radio receiver. Most of the time the signal path is switched off and only a sleep timer runs. When the timer expires, the path is enabled for a fixed settling time. The controller then watches the demodulated data line. If the edges on that line arrive at the spacing a real transmitter would produce, the controller locks into continuous reception and passes the data through. If they do not, it drops the path and goes back to sleep. All timing is counted in units of a basic clock tick, which is given as an enable input.

The sleep period is the product of three factors: a 5-bit programmable word, an extension factor of 1 or 8, and a fixed unit (`SLEEP_UNIT`, 1024 ticks by default). Each interval between data edges is measured in ticks. It must fall inside a half-bit window, and the window is chosen by a 2-bit baud-range code. A programmable number of consecutive good intervals is needed before the controller wakes. While the controller is receiving, an off request returns it to sleep.

Top module: `rx_poll_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to sleep, and `path_en`, `rx_active` and `data_out` all read 0 after that edge.
- R2: The sleep phase lasts W × X × `SLEEP_UNIT` ticks, with `path_en` low throughout. W is `cfg_sleep`, with 0 treated as 1. X is 1 when `cfg_xsleep` is 0 and 8 when it is 1. After the last sleep tick, `path_en` is high.
- R3: The start-up phase lasts exactly `STARTUP_TICKS` ticks with `path_en` high and `rx_active` low, and is then followed by the bit-check phase.
- R4: In bit-check, the controller measures the tick count between consecutive changes of `demod_in`. When N such intervals in a row each lie within [lo, hi], inclusive at both ends, the controller enters receive at the tick of the edge that closes the Nth interval. N is `cfg_nbits`, with 0 treated as 1.
- R5: In bit-check, an edge that closes an interval shorter than lo or longer than hi sends the controller to sleep at that tick.
- R6: In bit-check, if 2 × hi ticks pass after the phase starts or after the last edge with no further edge, the controller goes to sleep.
- R7: In receive, `path_en` and `rx_active` are high and `data_out` follows `demod_in` in the same cycle. In every other mode, `data_out` is 0 whatever `demod_in` is.
- R8: If `off_cmd` is high at a clock edge while the controller is receiving, it is asleep after that edge.
- R9: Cycles with `tick` low do not advance any phase timer.
- R10: The half-bit window depends on `cfg_baud` (value b): lo = `HB_BASE` << b and hi = 2 × lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Basic timing tick enable |
| demod_in | input | 1 | Demodulated data line |
| cfg_sleep | input | 5 | Sleep word W |
| cfg_xsleep | input | 1 | Sleep extension select (factor 1 or 8) |
| cfg_baud | input | 2 | Baud-range code for the half-bit window |
| cfg_nbits | input | 4 | Number of good intervals required |
| off_cmd | input | 1 | Off request while receiving |
| path_en | output | 1 | Signal path enable (high outside sleep) |
| rx_active | output | 1 | High while receiving |
| data_out | output | 1 | Gated data output |

## Verification
A timer that is off by one tick moves the rise of `path_en` or its drop back to sleep by a cycle. The bench pins every phase boundary to an exact cycle number, so such a slip shows on the first wake-up. A wrong window limit or a wrong interval count only shows in bit-check. It appears as a sleep where receive was expected, or receive one edge too early or late. The boundary cases place intervals exactly at lo and hi so that an error at either limit shows at the closing edge itself. A gating fault shows on `data_out` within the same cycle that `demod_in` changes.

// File: rtl/rx_poll_pkg.sv
`timescale 1ns/1ps
package rx_poll_pkg;

    typedef enum logic [1:0] {
        M_SLEEP = 2'd0,
        M_START = 2'd1,
        M_CHECK = 2'd2,
        M_RECV  = 2'd3
    } rxp_mode_e;

    // shortest accepted half-bit interval for a baud-range code
    function automatic int unsigned hb_lo(input int unsigned base, input logic [1:0] sel);
        return base << sel;
    endfunction

    // longest accepted half-bit interval for a baud-range code
    function automatic int unsigned hb_hi(input int unsigned base, input logic [1:0] sel);
        return 2 * (base << sel);
    endfunction

endpackage

// File: rtl/rx_poll_sleep.sv
`timescale 1ns/1ps
module rx_poll_sleep #(
    parameter int SLEEP_UNIT = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic [4:0] sleep_word,
    input  logic       xsleep,
    output logic       done
);
    localparam int CNT_W = $clog2(31 * 8 * SLEEP_UNIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } slp_t;

    slp_t             s_q, s_d;
    logic [4:0]       w_eff;
    logic [CNT_W-1:0] target;

    always_comb begin
        w_eff  = (sleep_word == 5'd0) ? 5'd1 : sleep_word;
        target = CNT_W'(w_eff) * CNT_W'(xsleep ? 8 : 1) * CNT_W'(SLEEP_UNIT);
        done   = run && tick && (s_q.cnt == target - CNT_W'(1));
        s_d    = s_q;
        if (!run)
            s_d.cnt = '0;
        else if (tick)
            s_d.cnt = done ? '0 : s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.cnt <= '0;
        else     s_q <= s_d;
    end

    // R2: the sleep count never passes the programmed length
    a_r2_cnt_below: assert property (@(posedge clk) disable iff (rst)
        run |-> (s_q.cnt < target));

    // R9: no tick, no progress
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(s_q.cnt));

endmodule

// File: rtl/rx_poll_bitchk.sv
`timescale 1ns/1ps
module rx_poll_bitchk
    import rx_poll_pkg::*;
#(
    parameter int HB_BASE = 4,
    parameter int NB_W    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            run,
    input  logic            data_in,
    input  logic [1:0]      baud_sel,
    input  logic [NB_W-1:0] nbits,
    output logic            pass,
    output logic            fail
);
    localparam int IVL_W = $clog2(4 * (HB_BASE << 3) + 1);

    typedef struct packed {
        logic             prev;
        logic             seen;
        logic [IVL_W-1:0] ivl;
        logic [NB_W:0]    good;
    } chk_t;

    chk_t             s_q, s_d;
    logic [IVL_W-1:0] lo, hi, tmo;
    logic [NB_W:0]    need;
    logic             edge_hit, in_win;

    always_comb begin
        lo       = IVL_W'(hb_lo(HB_BASE, baud_sel));
        hi       = IVL_W'(hb_hi(HB_BASE, baud_sel));
        tmo      = IVL_W'(2 * hb_hi(HB_BASE, baud_sel));
        need     = (nbits == '0) ? (NB_W+1)'(1) : {1'b0, nbits};
        edge_hit = tick && (data_in != s_q.prev);
        in_win   = (s_q.ivl >= lo) && (s_q.ivl <= hi);
        pass     = 1'b0;
        fail     = 1'b0;
        s_d      = s_q;
        if (tick) s_d.prev = data_in;
        if (!run) begin
            s_d.seen = 1'b0;
            s_d.ivl  = IVL_W'(1);
            s_d.good = '0;
        end else if (tick) begin
            if (edge_hit) begin
                s_d.seen = 1'b1;
                s_d.ivl  = IVL_W'(1);
                if (s_q.seen) begin
                    if (in_win) begin
                        s_d.good = s_q.good + (NB_W+1)'(1);
                        if (s_q.good + (NB_W+1)'(1) == need) pass = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end else if (s_q.ivl >= tmo) begin
                fail = 1'b1;
            end else begin
                s_d.ivl = s_q.ivl + IVL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.prev <= 1'b0;
            s_q.seen <= 1'b0;
            s_q.ivl  <= IVL_W'(1);
            s_q.good <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: the interval timer never runs past the timeout
    a_r6_ivl_cap: assert property (@(posedge clk) disable iff (rst)
        run |-> (s_q.ivl <= tmo));

    // R5: one verdict at a time
    a_r5_one_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass, fail}));

    // R4: good count stays short of the target while checking
    a_r4_good_short: assert property (@(posedge clk) disable iff (rst)
        run |-> (s_q.good < need));

endmodule

// File: rtl/rx_poll_ctrl.sv
`timescale 1ns/1ps
module rx_poll_ctrl
    import rx_poll_pkg::*;
#(
    parameter int SLEEP_UNIT    = 1024,
    parameter int STARTUP_TICKS = 64,
    parameter int HB_BASE       = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       demod_in,
    input  logic [4:0] cfg_sleep,
    input  logic       cfg_xsleep,
    input  logic [1:0] cfg_baud,
    input  logic [3:0] cfg_nbits,
    input  logic       off_cmd,
    output logic       path_en,
    output logic       rx_active,
    output logic       data_out
);
    localparam int SU_W = $clog2(STARTUP_TICKS + 1);

    typedef struct packed {
        rxp_mode_e       mode;
        logic [SU_W-1:0] su;
    } ctl_t;

    ctl_t s_q, s_d;
    logic slp_done, chk_pass, chk_fail;

    rx_poll_sleep #(.SLEEP_UNIT(SLEEP_UNIT)) u_sleep (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .run        (s_q.mode == M_SLEEP),
        .sleep_word (cfg_sleep),
        .xsleep     (cfg_xsleep),
        .done       (slp_done)
    );

    rx_poll_bitchk #(.HB_BASE(HB_BASE), .NB_W(4)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (s_q.mode == M_CHECK),
        .data_in  (demod_in),
        .baud_sel (cfg_baud),
        .nbits    (cfg_nbits),
        .pass     (chk_pass),
        .fail     (chk_fail)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            M_SLEEP: if (slp_done) begin
                s_d.mode = M_START;
                s_d.su   = '0;
            end
            M_START: if (tick) begin
                if (s_q.su == SU_W'(STARTUP_TICKS - 1)) begin
                    s_d.mode = M_CHECK;
                    s_d.su   = '0;
                end else begin
                    s_d.su = s_q.su + SU_W'(1);
                end
            end
            M_CHECK: begin
                if (chk_pass)      s_d.mode = M_RECV;
                else if (chk_fail) s_d.mode = M_SLEEP;
            end
            M_RECV: if (off_cmd) s_d.mode = M_SLEEP;
            default: s_d.mode = M_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.mode <= M_SLEEP;
            s_q.su   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign path_en   = (s_q.mode != M_SLEEP);
    assign rx_active = (s_q.mode == M_RECV);
    assign data_out  = rx_active & demod_in;

    // R1: reset lands in sleep
    a_r1_reset_sleep: assert property (@(posedge clk)
        rst |=> (s_q.mode == M_SLEEP));

    // R3: start-up leaves only towards bit-check
    a_r3_start_exit: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == M_START) |=> (s_q.mode == M_START || s_q.mode == M_CHECK));

    // R3: settling counter in range
    a_r3_su_bound: assert property (@(posedge clk) disable iff (rst)
        s_q.su < SU_W'(STARTUP_TICKS));

    // R4: receive is only ever entered from bit-check
    a_r4_recv_from_check: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == M_RECV && $past(s_q.mode) != M_RECV) |-> ($past(s_q.mode) == M_CHECK));

    // R8: off request while receiving returns to sleep
    a_r8_off_sleep: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == M_RECV && off_cmd) |=> (s_q.mode == M_SLEEP));

endmodule

// File: tb/rx_poll_ctrl_test.sv
`timescale 1ns/1ps
module rx_poll_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       demod_in = 1'b0;
    logic [4:0] cfg_sleep = 5'd3;
    logic       cfg_xsleep = 1'b0;
    logic [1:0] cfg_baud = 2'd0;
    logic [3:0] cfg_nbits = 4'd3;
    logic       off_cmd = 1'b0;
    logic       path_en, rx_active, data_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    typedef struct {
        int    cyc;
        logic  p;
        logic  r;
        logic  d;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    rx_poll_ctrl #(.SLEEP_UNIT(4), .STARTUP_TICKS(8), .HB_BASE(4)) uut (
        .clk(clk), .rst(rst), .tick(tick), .demod_in(demod_in),
        .cfg_sleep(cfg_sleep), .cfg_xsleep(cfg_xsleep), .cfg_baud(cfg_baud),
        .cfg_nbits(cfg_nbits), .off_cmd(off_cmd),
        .path_en(path_en), .rx_active(rx_active), .data_out(data_out)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor: compare queued expectations at their cycle
    always @(negedge clk) begin
        if (!rst) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (e.cyc != cyc || {path_en, rx_active, data_out} != {e.p, e.r, e.d}) begin
                    errors++;
                    $display("FAIL %s cyc %0d: got path/rx/data %b%b%b expected %b%b%b", e.tag,
                             cyc, path_en, rx_active, data_out, e.p, e.r, e.d);
                end
            end
        end
    end

    task automatic push(input int c, input logic p, input logic r, input logic d, input string tag);
        exp_t e;
        e.cyc = c; e.p = p; e.r = r; e.d = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic at_cyc(input int c);
        forever begin
            @(posedge clk); #1;
            if (cyc >= c) break;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({path_en, rx_active, data_out} != 3'b000) begin
            errors++;
            $display("FAIL R1 reset outputs: got %b%b%b expected 000", path_en, rx_active, data_out);
        end
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic setup(input logic [4:0] w, input logic x, input logic [1:0] b, input logic [3:0] n);
        demod_in = 1'b0; off_cmd = 1'b0; tick = 1'b1;
        cfg_sleep = w; cfg_xsleep = x; cfg_baud = b; cfg_nbits = n;
        do_reset();
    endtask

    initial begin
        // A: full wake-up, pass-through, off, re-poll
        setup(5'd3, 1'b0, 2'd0, 4'd3);
        push(11, 0, 0, 0, "R2"); push(12, 1, 0, 0, "R2");
        push(19, 1, 0, 0, "R3"); push(20, 1, 0, 0, "R3");
        push(23, 1, 0, 0, "R7");
        push(37, 1, 0, 0, "R4"); push(38, 1, 1, 0, "R4");
        push(39, 1, 1, 1, "R7");
        push(44, 1, 1, 1, "R8"); push(45, 0, 0, 0, "R8");
        push(56, 0, 0, 0, "R2"); push(57, 1, 0, 0, "R2");
        at_cyc(21); demod_in = ~demod_in;
        at_cyc(26); demod_in = ~demod_in;
        at_cyc(32); demod_in = ~demod_in;
        at_cyc(37); demod_in = ~demod_in;
        at_cyc(39); demod_in = 1'b1;
        at_cyc(44); off_cmd = 1'b1;
        at_cyc(45); off_cmd = 1'b0;
        drain();

        // B: interval too short (R5)
        setup(5'd3, 1'b0, 2'd0, 4'd3);
        push(23, 1, 0, 0, "R5"); push(24, 0, 0, 0, "R5");
        at_cyc(21); demod_in = ~demod_in;
        at_cyc(23); demod_in = ~demod_in;
        drain();

        // C: interval too long for range 0 (R5, R10)
        setup(5'd3, 1'b0, 2'd0, 4'd3);
        push(30, 1, 0, 0, "R5"); push(31, 0, 0, 0, "R5");
        at_cyc(21); demod_in = ~demod_in;
        at_cyc(30); demod_in = ~demod_in;
        drain();

        // D: no edges -> timeout, then re-poll (R6)
        setup(5'd3, 1'b0, 2'd0, 4'd3);
        push(35, 1, 0, 0, "R6"); push(36, 0, 0, 0, "R6");
        push(47, 0, 0, 0, "R6"); push(48, 1, 0, 0, "R6");
        drain();

        // E: zero word and extension factor (R2)
        setup(5'd0, 1'b1, 2'd0, 4'd3);
        push(31, 0, 0, 0, "R2"); push(32, 1, 0, 0, "R2");
        drain();

        // F: wider window on range 1, single interval (R10), then reset (R1)
        setup(5'd1, 1'b0, 2'd1, 4'd1);
        push(23, 1, 0, 0, "R10"); push(24, 1, 1, 0, "R10");
        at_cyc(13); demod_in = ~demod_in;
        at_cyc(23); demod_in = ~demod_in;
        drain();
        at_cyc(26); demod_in = 1'b1;
        do_reset();

        // G: intervals exactly at lo and hi (R4)
        setup(5'd1, 1'b0, 2'd0, 4'd2);
        push(24, 1, 0, 0, "R4"); push(25, 1, 1, 1, "R4");
        at_cyc(12); demod_in = ~demod_in;
        at_cyc(16); demod_in = ~demod_in;
        at_cyc(24); demod_in = ~demod_in;
        drain();

        // H: tick held low freezes the sleep timer (R9)
        demod_in = 1'b0; cfg_sleep = 5'd1; cfg_xsleep = 1'b0; cfg_nbits = 4'd3;
        tick = 1'b0;
        do_reset();
        push(13, 0, 0, 0, "R9"); push(14, 1, 0, 0, "R9");
        at_cyc(10); tick = 1'b1;
        drain();

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #750000;
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule